// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two unsigned operands of `W` bits (32 by default) and returns the full `2W`-bit product as an upper and a lower word. It uses one `W`-bit adder and takes one cycle per multiplier bit. The product register is `2W` bits wide. When a multiply starts, its lower half is loaded with the multiplier and its upper half is cleared.

On each step the least significant bit of the product register decides whether the multiplicand is added into the upper half. The sum and its carry-out are then written back with the whole register shifted right by one position. The carry becomes the new top bit. Each shift moves one consumed multiplier bit out at the bottom and one finished product bit into the lower half.

The caller pulses `start_i` with both operands. It then waits for the one-cycle `done_o` pulse and reads `hi_o` and `lo_o`. The result stays on those outputs until the next accepted start.

Top module: `shift_add_mul`

## Requirements
- R1: While `rst_ni` is low, and after it is released with no start, `busy_o` and `done_o` are 0 and `hi_o`/`lo_o` are 0.
- R2: A start (`start_i` = 1 while `busy_o` = 0) captures both operands at that clock edge. In the next cycle `busy_o` is 1, `hi_o` is 0 and `lo_o` equals the captured multiplier. Operand inputs are ignored in every other cycle.
- R3: `done_o` rises exactly `W` clock edges after the accepting edge and stays high for one cycle. In that same cycle `busy_o` falls to 0. `busy_o` and `done_o` are never both 1.
- R4: When `done_o` is 1, `{hi_o, lo_o}` equals the unsigned `2W`-bit product of the captured multiplicand and multiplier. For example, 8 x 9 gives `lo_o` = 72 and `hi_o` = 0.
- R5: The carry-out of each addition becomes the top product bit in the same step. With both operands all ones, the result is `{hi_o, lo_o}` = 0xFFFFFFFE_00000001.
- R6: A start pulse while `busy_o` is 1 is ignored. The running multiply proceeds unchanged and returns its own product.
- R7: After `done_o`, `hi_o`/`lo_o` hold their value and `done_o` stays 0 until the next accepted start.
- R8: After step k (1..W) of a multiply of a by b, `{hi_o, lo_o}` equals (a * (b mod 2^k)) shifted left by W-k, plus (b >> k).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a multiply; accepted only while idle |
| mcand_i | input | W | Multiplicand, sampled on an accepted start |
| mplier_i | input | W | Multiplier, sampled on an accepted start |
| busy_o | output | 1 | Multiply in progress |
| done_o | output | 1 | One-cycle pulse when the product is ready |
| hi_o | output | W | Upper half of product register |
| lo_o | output | W | Lower half of product register |

## Verification
The assertions assume three things about the inputs:
- Reset is applied before the first start.
- `start_i` is always a defined 0 or 1.
- The operands are defined in the cycle a start is accepted. Their value at any other time does not matter, because the block captures them at that edge.

The stimulus changes inputs only on the falling clock edge and holds reset low from time zero. It drives the operands with unrelated values outside the accepting cycle, which checks that those values are indeed ignored. It places one extra start pulse in the middle of a running multiply, so the rule that a busy block ignores `start_i` is exercised and not assumed.

// File: rtl/shift_add_mul_pkg.sv
package shift_add_mul_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } mul_state_e;
endpackage

// File: rtl/mul_adder.sv
module mul_adder #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         en_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  logic [W-1:0] addend;

  always_comb begin
    addend          = en_i ? b_i : '0;
    {cout_o, sum_o} = {1'b0, a_i} + {1'b0, addend};
  end
endmodule

// File: rtl/mul_ctrl.sv
module mul_ctrl
  import shift_add_mul_pkg::*;
#(
  parameter int W = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  mul_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic          last_step;

  assign busy_o    = (state_q == ST_RUN);
  assign load_o    = start_i && !busy_o;
  assign step_o    = busy_o;
  assign last_step = busy_o && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= last_step;
      if (load_o) begin
        state_q <= ST_RUN;
        cnt_q   <= '0;
      end else if (last_step) begin
        state_q <= ST_IDLE;
      end else if (busy_o) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mul_datapath.sv
module mul_datapath #(
  parameter int W = 32
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic           step_i,
  input  logic [W-1:0]   mcand_i,
  input  logic [W-1:0]   mplier_i,
  output logic [2*W-1:0] prod_o
);
  localparam int PW = 2 * W;

  logic [W-1:0]  mcand_q;
  logic [PW-1:0] prod_q;
  logic [W-1:0]  sum;
  logic          cout;

  mul_adder #(.W(W)) u_add (
    .a_i   (prod_q[PW-1:W]),
    .b_i   (mcand_q),
    .en_i  (prod_q[0]),
    .sum_o (sum),
    .cout_o(cout)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mcand_q <= '0;
      prod_q  <= '0;
    end else if (load_i) begin
      mcand_q <= mcand_i;
      prod_q  <= {{W{1'b0}}, mplier_i};
    end else if (step_i) begin
      // carry lands in the top bit as the register shifts right
      prod_q <= {cout, sum, prod_q[W-1:1]};
    end
  end

  assign prod_o = prod_q;
endmodule

// File: rtl/shift_add_mul.sv
module shift_add_mul #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] mcand_i,
  input  logic [W-1:0] mplier_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] hi_o,
  output logic [W-1:0] lo_o
);
  logic           load;
  logic           step;
  logic [2*W-1:0] prod;

  mul_ctrl #(.W(W)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .load_o (load),
    .step_o (step),
    .busy_o (busy_o),
    .done_o (done_o)
  );

  mul_datapath #(.W(W)) u_dp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .step_i  (step),
    .mcand_i (mcand_i),
    .mplier_i(mplier_i),
    .prod_o  (prod)
  );

  assign hi_o = prod[2*W-1:W];
  assign lo_o = prod[W-1:0];
endmodule

// File: rtl/shift_add_mul_chk.sv
module shift_add_mul_chk #(
  parameter int W = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_i,
  input logic [W-1:0] mcand_i,
  input logic [W-1:0] mplier_i,
  input logic         busy_o,
  input logic         done_o,
  input logic [W-1:0] hi_o,
  input logic [W-1:0] lo_o
);
  localparam int CW = $clog2(W + 1) + 1;

  logic [CW-1:0]  run_cnt_q;
  logic [2*W-1:0] exp_q;
  logic           accept;

  assign accept = start_i && !busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_cnt_q <= '0;
      exp_q     <= '0;
    end else if (accept) begin
      run_cnt_q <= '0;
      exp_q     <= (2*W)'(mcand_i) * (2*W)'(mplier_i);
    end else if (busy_o) begin
      run_cnt_q <= run_cnt_q + 1'b1;
    end
  end

  // R2
  start_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> busy_o && (hi_o == '0) && (lo_o == $past(mplier_i)));

  // R3
  busy_done_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));

  // R3
  done_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (run_cnt_q == CW'(W)) && $past(busy_o));

  // R3
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R4 R6
  product_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ({hi_o, lo_o} == exp_q));

  // R7
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !start_i |=> $stable(hi_o) && $stable(lo_o) && !done_o);
endmodule

bind shift_add_mul shift_add_mul_chk #(.W(W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .mcand_i (mcand_i),
  .mplier_i(mplier_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .hi_o    (hi_o),
  .lo_o    (lo_o)
);

// File: tb/shift_add_mul_test.sv
module shift_add_mul_test;
  localparam int W = 32;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic [W-1:0] mcand_i = '0;
  logic [W-1:0] mplier_i = '0;
  logic         busy_o;
  logic         done_o;
  logic [W-1:0] hi_o;
  logic [W-1:0] lo_o;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk_i = ~clk_i;

  shift_add_mul #(.W(W)) uut (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .mcand_i (mcand_i),
    .mplier_i(mplier_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .hi_o    (hi_o),
    .lo_o    (lo_o)
  );

  task automatic check(input bit ok, input string tag, input logic [2*W-1:0] act,
                       input logic [2*W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic run_mul(input logic [W-1:0] a, input logic [W-1:0] b, input bit inject);
    logic [2*W-1:0] part;
    logic [2*W-1:0] mask;
    logic [2*W-1:0] full;
    full = (2*W)'(a) * (2*W)'(b);
    @(negedge clk_i);
    start_i  = 1'b1;
    mcand_i  = a;
    mplier_i = b;
    @(negedge clk_i);
    start_i  = 1'b0;
    mcand_i  = ~a ^ 32'h5a5a_0f0f;
    mplier_i = ~b;
    // R2 load state
    check(busy_o && !done_o && {hi_o, lo_o} == {{W{1'b0}}, b}, "R2",
          {hi_o, lo_o}, {{W{1'b0}}, b});
    for (int k = 1; k <= W; k++) begin
      if (inject && k == 9) begin
        start_i  = 1'b1;
        mcand_i  = 32'h1357_9bdf;
        mplier_i = 32'h2468_ace0;
      end
      @(negedge clk_i);
      start_i = 1'b0;
      mask = (k == W) ? '1 : (((2*W)'(1) << k) - 1'b1);
      part = ((((2*W)'(a)) * ((2*W)'(b) & mask)) << (W - k)) + ((2*W)'(b) >> k);
      // R3 busy/done timing
      check(busy_o == (k < W) && done_o == (k == W), "R3",
            {62'd0, busy_o, done_o}, {62'd0, k < W, k == W});
      // R8 per-step product register
      check({hi_o, lo_o} == part, inject ? "R6/R8" : "R8", {hi_o, lo_o}, part);
    end
    // R4 R5 final product
    check({hi_o, lo_o} == full, (a == '1 && b == '1) ? "R5" : "R4", {hi_o, lo_o}, full);
    repeat (3) @(negedge clk_i);
    // R7 hold after completion
    check(!busy_o && !done_o && {hi_o, lo_o} == full, "R7", {hi_o, lo_o}, full);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 during reset
    check(!busy_o && !done_o && hi_o == '0 && lo_o == '0, "R1", {hi_o, lo_o}, '0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    // R1 after release
    check(!busy_o && !done_o && hi_o == '0 && lo_o == '0, "R1", {hi_o, lo_o}, '0);

    run_mul(32'd8, 32'd9, 1'b0);
    run_mul('1, '1, 1'b0);
    run_mul('1, 32'd1, 1'b0);
    run_mul(32'd1, '1, 1'b0);
    run_mul(32'd0, '1, 1'b0);
    run_mul(32'h8000_0000, 32'h8000_0000, 1'b0);
    run_mul(32'hdead_beef, 32'hcafe_f00d, 1'b1);
    run_mul('1, 32'h8000_0001, 1'b1);
    for (int i = 0; i < W; i++) run_mul(32'd1 << i, ~(32'd1 << i), 1'b0);
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        run_mul(W'(a), W'(b), 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule